// File: doc/BRIEF.md
# Read Data Integrity Checker

This block checks the data returned by a memory test engine's read responses. Each write leaves the engine with a small transaction ID. The block records that write's address and data in a table with one slot per ID, and marks the slot as outstanding. When a read response arrives carrying the same ID, the block looks up the recorded data and compares it with the returned data in the same cycle. Responses may therefore return in any order.

A per-bit mask removes chosen data bits from the compare, so one faulty lane can be isolated. Two saturating counters keep the statistics. One counts responses that the memory interface itself flags as errors, together with reads that arrive for a slot that has nothing outstanding. The other counts data mismatches.

The ID, address, expected data and returned data of the first failing read are latched and held until software clears them. A stop request can be raised to halt the traffic generator on the first error. The generator can also be left running.

Top module: `idc_checker`

## Requirements
- R1: A write issue (`wr_vld`=1) records `wr_addr` and `wr_data` in the slot selected by `wr_id` and marks that slot outstanding. Later reads of that ID are checked against the recorded values, whatever order the IDs return in.
- R2: A read response (`rd_vld`=1) frees its slot. A second read response to the same ID without an intervening write is therefore an orphan.
- R3: A read response with `rd_err`=0 to an outstanding slot whose unmasked data differs from the recorded data adds one to `mism_cnt`. The new value is visible after the clock edge that samples the response.
- R4: A data bit whose `cmp_mask` bit is 1 is excluded from the compare. A response whose data differs only in masked bits is not a mismatch.
- R5: A read response with `rd_err`=1 adds one to `bus_err_cnt` and never adds to `mism_cnt`, whatever data it returns.
- R6: A write response with `wr_rsp_vld`=1 and `wr_rsp_err`=1 adds one to `bus_err_cnt`. When it coincides with a read-side bus error, the counter gains two in that cycle.
- R7: A read response with `rd_err`=0 to a slot that is not outstanding (an orphan) adds one to `bus_err_cnt` and not to `mism_cnt`.
- R8: The first failing read latches its details. A failing read is a mismatch, an orphan or `rd_err`. The latched values are the ID, the recorded address, the recorded (expected) data and the returned data, and `fail_vld` is set. The latched values stay unchanged on later failures.
- R9: `clr`=1 for one cycle zeroes both counters, clears `fail_vld` and drops `stop_req`. It takes priority over any event in the same cycle.
- R10: Both counters saturate at all-ones instead of wrapping.
- R11: With `stop_on_err`=1, any counted error raises `stop_req`, which is held until `clr`. With `stop_on_err`=0, `stop_req` stays 0.
- R12: After reset both counters are 0, `fail_vld` is 0, `stop_req` is 0 and no slot is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Clear counters, first-fail record and stop request |
| stop_on_err | input | 1 | 1: request a halt on the first error |
| cmp_mask | input | DATA_W | 1 excludes the data bit from the compare |
| wr_vld | input | 1 | Write issue strobe |
| wr_id | input | ID_W | Transaction ID of the issued write |
| wr_addr | input | ADDR_W | Address of the issued write |
| wr_data | input | DATA_W | Data of the issued write |
| wr_rsp_vld | input | 1 | Write response strobe |
| wr_rsp_err | input | 1 | Write response flagged as an error |
| rd_vld | input | 1 | Read response strobe |
| rd_id | input | ID_W | Transaction ID of the read response |
| rd_data | input | DATA_W | Returned read data |
| rd_err | input | 1 | Read response flagged as an error |
| bus_err_cnt | output | CNT_W | Interface-error and orphan counter |
| mism_cnt | output | CNT_W | Data mismatch counter |
| fail_vld | output | 1 | A first failure has been latched |
| fail_id | output | ID_W | ID of the first failing read |
| fail_addr | output | ADDR_W | Recorded address of the first failing read |
| fail_exp | output | DATA_W | Expected data of the first failing read |
| fail_got | output | DATA_W | Returned data of the first failing read |
| stop_req | output | 1 | Halt request to the traffic generator |

## Verification
The bench builds the checker with ID_W=4, ADDR_W=8, DATA_W=16 and CNT_W=3. The full 16-slot table is therefore present, while the 3-bit counters reach their all-ones ceiling after only seven errors. Because of that short ceiling, the saturation and the double-increment cycle can both be reached in a handful of directed cycles. The 16-bit data width keeps the mask vectors short enough to place isolated single-bit and half-word differences both inside and outside the mask.

// File: rtl/idc_pkg.sv
package idc_pkg;
  typedef enum logic [1:0] {
    RSP_PASS   = 2'd0,
    RSP_MISM   = 2'd1,
    RSP_ORPHAN = 2'd2,
    RSP_BUSERR = 2'd3
  } rsp_class_e;
endpackage

// File: rtl/idc_exp_table.sv
module idc_exp_table #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_vld,
  input  logic [ID_W-1:0]   rd_id,
  output logic              lk_valid,
  output logic [ADDR_W-1:0] lk_addr,
  output logic [DATA_W-1:0] lk_data
);
  localparam int DEPTH = 1 << ID_W;

  logic [DEPTH-1:0]  slot_valid;
  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    wire slot_fill = wr_vld && (wr_id == ID_W'(e));
    wire slot_free = rd_vld && (rd_id == ID_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_valid[e] <= 1'b0;
        slot_addr[e]  <= '0;
        slot_data[e]  <= '0;
      end else if (slot_fill) begin
        slot_valid[e] <= 1'b1;
        slot_addr[e]  <= wr_addr;
        slot_data[e]  <= wr_data;
      end else if (slot_free) begin
        slot_valid[e] <= 1'b0;
      end
    end
  end

  assign lk_valid = slot_valid[rd_id];
  assign lk_addr  = slot_addr[rd_id];
  assign lk_data  = slot_data[rd_id];

  assert_slot_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |=> slot_valid[$past(wr_id)]);

  assert_slot_freed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && !(wr_vld && wr_id == rd_id)) |=> !slot_valid[$past(rd_id)]);
endmodule

// File: rtl/idc_compare.sv
module idc_compare
  import idc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              rd_vld,
  input  logic              rd_err,
  input  logic              lk_valid,
  input  logic [DATA_W-1:0] exp_data,
  input  logic [DATA_W-1:0] got_data,
  input  logic [DATA_W-1:0] cmp_mask,
  output rsp_class_e        rsp_class,
  output logic              ev_rd_fail,
  output logic              ev_rd_mism,
  output logic              ev_rd_bus
);
  function automatic logic masked_differs(input logic [DATA_W-1:0] e,
                                          input logic [DATA_W-1:0] g,
                                          input logic [DATA_W-1:0] m);
    return |((e ^ g) & ~m);
  endfunction

  always_comb begin
    if (rd_err)        rsp_class = RSP_BUSERR;
    else if (!lk_valid) rsp_class = RSP_ORPHAN;
    else if (masked_differs(exp_data, got_data, cmp_mask)) rsp_class = RSP_MISM;
    else               rsp_class = RSP_PASS;
  end

  assign ev_rd_mism = rd_vld && (rsp_class == RSP_MISM);
  assign ev_rd_bus  = rd_vld && (rsp_class == RSP_BUSERR || rsp_class == RSP_ORPHAN);
  assign ev_rd_fail = ev_rd_mism || ev_rd_bus;
endmodule

// File: rtl/idc_err_stats.sv
module idc_err_stats #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              stop_on_err,
  input  logic              ev_rd_fail,
  input  logic              ev_rd_mism,
  input  logic              ev_rd_bus,
  input  logic              ev_wr_bus,
  input  logic [ID_W-1:0]   cap_id,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_exp,
  input  logic [DATA_W-1:0] cap_got,
  output logic [CNT_W-1:0]  bus_err_cnt,
  output logic [CNT_W-1:0]  mism_cnt,
  output logic              fail_vld,
  output logic [ID_W-1:0]   fail_id,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_got,
  output logic              stop_req
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] c,
                                               input logic [1:0] inc);
    logic [CNT_W:0] s;
    s = {1'b0, c} + (CNT_W+1)'(inc);
    return s[CNT_W] ? CNT_MAX : s[CNT_W-1:0];
  endfunction

  wire [1:0] bus_inc = {1'b0, ev_rd_bus} + {1'b0, ev_wr_bus};
  wire       any_err = ev_rd_fail || ev_wr_bus;
  wire       capture = ev_rd_fail && !fail_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_err_cnt <= '0;
      mism_cnt    <= '0;
      stop_req    <= 1'b0;
    end else if (clr) begin
      bus_err_cnt <= '0;
      mism_cnt    <= '0;
      stop_req    <= 1'b0;
    end else begin
      bus_err_cnt <= sat_add(bus_err_cnt, bus_inc);
      mism_cnt    <= sat_add(mism_cnt, {1'b0, ev_rd_mism});
      if (any_err && stop_on_err) stop_req <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_vld  <= 1'b0;
      fail_id   <= '0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_got  <= '0;
    end else if (clr) begin
      fail_vld  <= 1'b0;
    end else if (capture) begin
      fail_vld  <= 1'b1;
      fail_id   <= cap_id;
      fail_addr <= cap_addr;
      fail_exp  <= cap_exp;
      fail_got  <= cap_got;
    end
  end

  assert_mism_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_mism && !clr && mism_cnt != CNT_MAX) |=> mism_cnt == CNT_W'($past(mism_cnt) + 1'b1));

  assert_no_mism_on_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_bus && !clr) |=> $stable(mism_cnt));

  assert_mism_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mism_cnt == CNT_MAX && !clr) |=> mism_cnt == CNT_MAX);

  assert_bus_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err_cnt == CNT_MAX && !clr) |=> bus_err_cnt == CNT_MAX);

  assert_fail_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_vld && !clr) |=> fail_vld && $stable(fail_id) && $stable(fail_addr)
                           && $stable(fail_exp) && $stable(fail_got));

  assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bus_err_cnt == '0 && mism_cnt == '0 && !fail_vld && !stop_req));

  assert_stop_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !clr) |=> stop_req);

  assert_stop_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req) |-> $past(stop_on_err));
endmodule

// File: rtl/idc_checker.sv
module idc_checker
  import idc_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              stop_on_err,
  input  logic [DATA_W-1:0] cmp_mask,
  input  logic              wr_vld,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_rsp_vld,
  input  logic              wr_rsp_err,
  input  logic              rd_vld,
  input  logic [ID_W-1:0]   rd_id,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_err,
  output logic [CNT_W-1:0]  bus_err_cnt,
  output logic [CNT_W-1:0]  mism_cnt,
  output logic              fail_vld,
  output logic [ID_W-1:0]   fail_id,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_got,
  output logic              stop_req
);
  logic              lk_valid;
  logic [ADDR_W-1:0] lk_addr;
  logic [DATA_W-1:0] lk_data;
  rsp_class_e        rsp_class;
  logic              ev_rd_fail;
  logic              ev_rd_mism;
  logic              ev_rd_bus;
  wire               ev_wr_bus = wr_rsp_vld && wr_rsp_err;

  idc_exp_table #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_vld   (wr_vld),
    .wr_id    (wr_id),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_vld   (rd_vld),
    .rd_id    (rd_id),
    .lk_valid (lk_valid),
    .lk_addr  (lk_addr),
    .lk_data  (lk_data)
  );

  idc_compare #(.DATA_W(DATA_W)) u_cmp (
    .rd_vld     (rd_vld),
    .rd_err     (rd_err),
    .lk_valid   (lk_valid),
    .exp_data   (lk_data),
    .got_data   (rd_data),
    .cmp_mask   (cmp_mask),
    .rsp_class  (rsp_class),
    .ev_rd_fail (ev_rd_fail),
    .ev_rd_mism (ev_rd_mism),
    .ev_rd_bus  (ev_rd_bus)
  );

  idc_err_stats #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_stats (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .stop_on_err (stop_on_err),
    .ev_rd_fail  (ev_rd_fail),
    .ev_rd_mism  (ev_rd_mism),
    .ev_rd_bus   (ev_rd_bus),
    .ev_wr_bus   (ev_wr_bus),
    .cap_id      (rd_id),
    .cap_addr    (lk_addr),
    .cap_exp     (lk_data),
    .cap_got     (rd_data),
    .bus_err_cnt (bus_err_cnt),
    .mism_cnt    (mism_cnt),
    .fail_vld    (fail_vld),
    .fail_id     (fail_id),
    .fail_addr   (fail_addr),
    .fail_exp    (fail_exp),
    .fail_got    (fail_got),
    .stop_req    (stop_req)
  );

  assert_one_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> $onehot0({ev_rd_mism, ev_rd_bus}));

  assert_orphan_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && !rd_err && !lk_valid) |-> (ev_rd_bus && !ev_rd_mism));
endmodule

// File: tb/test_idc_checker.sv
module test_idc_checker;
  localparam int ID_W = 4, ADDR_W = 8, DATA_W = 16, CNT_W = 3;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, stop_on_err = 1'b0;
  logic [DATA_W-1:0] cmp_mask = '0;
  logic wr_vld = 1'b0, wr_rsp_vld = 1'b0, wr_rsp_err = 1'b0, rd_vld = 1'b0, rd_err = 1'b0;
  logic [ID_W-1:0] wr_id = '0, rd_id = '0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0, rd_data = '0;
  logic [CNT_W-1:0] bus_err_cnt, mism_cnt;
  logic fail_vld, stop_req;
  logic [ID_W-1:0] fail_id;
  logic [ADDR_W-1:0] fail_addr;
  logic [DATA_W-1:0] fail_exp, fail_got;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  idc_checker #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_idc_checker (
    .clk(clk), .rst_n(rst_n), .clr(clr), .stop_on_err(stop_on_err), .cmp_mask(cmp_mask),
    .wr_vld(wr_vld), .wr_id(wr_id), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_rsp_vld(wr_rsp_vld), .wr_rsp_err(wr_rsp_err),
    .rd_vld(rd_vld), .rd_id(rd_id), .rd_data(rd_data), .rd_err(rd_err),
    .bus_err_cnt(bus_err_cnt), .mism_cnt(mism_cnt), .fail_vld(fail_vld), .fail_id(fail_id),
    .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_got(fail_got), .stop_req(stop_req)
  );

  // vector: {write data, read data, mask, expected mismatch}
  localparam logic [48:0] VEC [8] = '{
    {16'hA5A5, 16'hA5A5, 16'h0000, 1'b0},
    {16'hA5A5, 16'hA5A4, 16'h0000, 1'b1},
    {16'hA5A5, 16'hA5A4, 16'h0001, 1'b0},
    {16'hFFFF, 16'h7FFF, 16'h0000, 1'b1},
    {16'hFFFF, 16'h7FFF, 16'h8000, 1'b0},
    {16'h1234, 16'h1234, 16'hFFFF, 1'b0},
    {16'h0000, 16'hFFFF, 16'hFF00, 1'b1},
    {16'h0F0F, 16'hF0F0, 16'hFFFF, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_vld = 0; rd_vld = 0; rd_err = 0; wr_rsp_vld = 0; wr_rsp_err = 0; clr = 0;
  endtask

  task automatic do_write(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d);
    wr_vld = 1; wr_id = id; wr_addr = a; wr_data = d;
    @(negedge clk); idle();
  endtask

  task automatic do_read(input logic [ID_W-1:0] id, input logic [DATA_W-1:0] d, input logic e);
    rd_vld = 1; rd_id = id; rd_data = d; rd_err = e;
    @(negedge clk); idle();
  endtask

  task automatic do_wrsp();
    wr_rsp_vld = 1; wr_rsp_err = 1;
    @(negedge clk); idle();
  endtask

  task automatic do_clr();
    clr = 1;
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 bus_err_cnt", 32'(bus_err_cnt), 0);
    chk("R12 mism_cnt", 32'(mism_cnt), 0);
    chk("R12 fail_vld", 32'(fail_vld), 0);
    chk("R12 stop_req", 32'(stop_req), 0);

    // R3/R4 vector table
    for (int i = 0; i < 8; i++) begin
      do_clr();
      cmp_mask = VEC[i][16:1];
      do_write(ID_W'(i), ADDR_W'(i), VEC[i][48:33]);
      do_read(ID_W'(i), VEC[i][32:17], 1'b0);
      chk($sformatf("R3/R4 vector %0d mism_cnt", i), 32'(mism_cnt), 32'(VEC[i][0]));
      chk($sformatf("R4 vector %0d bus_err_cnt", i), 32'(bus_err_cnt), 0);
    end
    cmp_mask = '0;

    // R1 out-of-order return
    do_clr();
    do_write(4'd3, 8'h33, 16'h1111);
    do_write(4'd7, 8'h77, 16'h2222);
    do_read(4'd7, 16'h2222, 1'b0);
    do_read(4'd3, 16'h1111, 1'b0);
    chk("R1 out-of-order mism_cnt", 32'(mism_cnt), 0);
    chk("R1 out-of-order bus_err_cnt", 32'(bus_err_cnt), 0);
    // R2/R7 second read of a freed slot is an orphan
    do_read(4'd3, 16'h1111, 1'b0);
    chk("R2 R7 orphan bus_err_cnt", 32'(bus_err_cnt), 1);
    chk("R7 orphan mism_cnt", 32'(mism_cnt), 0);
    chk("R8 orphan latched id", 32'(fail_id), 3);

    // R8 first fail capture and freeze
    do_clr();
    chk("R9 fail_vld cleared", 32'(fail_vld), 0);
    do_write(4'd5, 8'h55, 16'hABCD);
    do_read(4'd5, 16'hABCF, 1'b0);
    chk("R8 fail_vld", 32'(fail_vld), 1);
    chk("R8 fail_id", 32'(fail_id), 5);
    chk("R8 fail_addr", 32'(fail_addr), 32'h55);
    chk("R8 fail_exp", 32'(fail_exp), 32'hABCD);
    chk("R8 fail_got", 32'(fail_got), 32'hABCF);
    do_write(4'd6, 8'h66, 16'h0001);
    do_read(4'd6, 16'h0002, 1'b0);
    chk("R8 frozen id", 32'(fail_id), 5);
    chk("R8 frozen got", 32'(fail_got), 32'hABCF);
    chk("R3 second mismatch", 32'(mism_cnt), 2);

    // R5 read error never compares
    do_clr();
    do_write(4'd9, 8'h99, 16'h0000);
    do_read(4'd9, 16'hFFFF, 1'b1);
    chk("R5 bus_err_cnt", 32'(bus_err_cnt), 1);
    chk("R5 mism_cnt", 32'(mism_cnt), 0);

    // R6 write response errors, alone and paired with a read error
    do_clr();
    do_wrsp();
    chk("R6 single wr error", 32'(bus_err_cnt), 1);
    do_write(4'd10, 8'hAA, 16'h0BAD);
    rd_vld = 1; rd_id = 4'd10; rd_data = 16'h0BAD; rd_err = 1;
    wr_rsp_vld = 1; wr_rsp_err = 1;
    @(negedge clk); idle();
    chk("R6 double increment", 32'(bus_err_cnt), 3);

    // R10 saturation
    for (int k = 0; k < 6; k++) do_wrsp();
    chk("R10 bus saturated", 32'(bus_err_cnt), 7);
    for (int k = 0; k < 9; k++) begin
      do_write(4'd12, 8'hC0, 16'h0000);
      do_read(4'd12, 16'h0001, 1'b0);
    end
    chk("R10 mism saturated", 32'(mism_cnt), 7);

    // R11 stop request
    chk("R11 no stop when disabled", 32'(stop_req), 0);
    do_clr();
    chk("R9 counters cleared", 32'(bus_err_cnt) + 32'(mism_cnt), 0);
    stop_on_err = 1;
    @(negedge clk);
    chk("R11 no stop before error", 32'(stop_req), 0);
    do_wrsp();
    chk("R11 stop raised", 32'(stop_req), 1);
    stop_on_err = 0;
    repeat (3) @(negedge clk);
    chk("R11 stop held", 32'(stop_req), 1);
    do_clr();
    chk("R9 stop cleared", 32'(stop_req), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule